// File: doc/BRIEF.md
# NAND Prefetch/Postwrite FIFO Engine

This block moves a programmed number of bytes between a NAND flash port and a processor or DMA side through a 64-byte FIFO. In prefetch (read) mode it fetches NAND data ahead of the consumer. Each fill takes as many bytes as fit in the FIFO and remain in the transfer. After the consumer has drained a programmable threshold of bytes, the engine starts another fill and deasserts its DMA request. In postwrite (write) mode each byte the processor writes is forwarded to the NAND port. For a 16-bit device, two consecutive bytes are paired into one halfword write.

Software programs a configuration word, a 14-bit byte count and a start bit through a small register port. It then either polls a status word or waits for the interrupt. Two sources drive the interrupt. The FIFO event is level-driven and tracks whether occupancy has reached the threshold. The terminal-count event fires when the byte count is exhausted. NAND traffic uses a request/acknowledge handshake: one byte, or one halfword on a 16-bit device, per acknowledge.

Top module: `nand_fifo_engine`

## Requirements
- R1: After reset the configuration word reads 0x4000. Writes keep only the bits of mask 0x7F8F7FBF. Bit 0 selects write mode and bit 2 enables the DMA request. Bits 14:8 hold the threshold and bits 26:24 drive `nand_cs`. Register addresses: 0 configuration, 1 byte count, 2 control (bit 0 start), 3 status, 4 interrupt status, 5 interrupt enable.
- R2: Writes to the configuration word and to the 14-bit byte count are ignored while the engine is started.
- R3: Setting the start bit loads the remaining count from the byte count. In read mode the FIFO pointer becomes 0 and a fill begins. In write mode it becomes 64. Starting also clears the DMA request.
- R4: A fill fetches min(64 − occupancy, remaining) bytes, rounded down to even on a 16-bit device. The remaining count drops by the bytes fetched. A halfword places its low byte first, and bytes leave the FIFO in fetch order.
- R5: When the remaining count reaches zero while started, interrupt status bit 1 is set and the start bit clears. In read mode this happens when the fill finishes.
- R6: Interrupt status bit 0 is set on every cycle in which occupancy ≥ threshold, so clearing it while the condition holds has no lasting effect. The status word carries the pointer in bits 30:24, the flag occupancy ≥ threshold in bit 16, and the remaining count in bits 13:0.
- R7: Interrupt status is cleared by writing ones. Only bits 0xF03 of the enable register are writable. `irq` is high when any status bit is set together with its enable bit.
- R8: With configuration bit 2 set, `dma_req` rises when a fill finishes with data in the FIFO. It falls when a read brings occupancy down to 64 − threshold, and that read also starts a refill. With bit 2 clear, `dma_req` never rises.
- R9: A read of an empty FIFO returns the last byte read again. A read in write mode returns 0. A write in read mode, or after the count has reached zero, produces no NAND write.
- R10: In write mode on a 16-bit device, the first byte is held and the pointer reads 63. The second byte forms the upper half of a single halfword NAND write, and only then does the remaining count drop by one.
- R11: Clearing the start bit during a transfer zeroes the remaining count and stops fetching. Bytes already in the FIFO can still be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| fifo_rd | input | 1 | FIFO byte read strobe |
| fifo_rdata | output | 8 | Byte returned by the last FIFO read |
| fifo_wr | input | 1 | FIFO byte write strobe |
| fifo_wdata | input | 8 | FIFO byte write data |
| dev_wide | input | 1 | Attached NAND device is 16 bits wide |
| nand_req | output | 1 | NAND transfer request, held until acknowledge |
| nand_we | output | 1 | Request is a write |
| nand_cs | output | 3 | Selected chip select |
| nand_wdata | output | 16 | NAND write data |
| nand_ack | input | 1 | NAND transfer acknowledge |
| nand_rdata | input | 16 | NAND read data, valid with acknowledge |
| irq | output | 1 | Interrupt |
| dma_req | output | 1 | DMA request |

## Verification
The hardest state to reach is a refill triggered part-way through a transfer. This needs a threshold that does not divide the count, so the final fill is shorter than the threshold and a later threshold crossing triggers a fill of zero bytes. The stimulus uses a 100-byte transfer with a threshold of 16 and reads one byte at a time, then runs one read past empty. A behavioural model tracks occupancy, remaining count, DMA request and both status bits, and is compared after every step. Forced stop, the ignored configuration writes, and a 16-bit read with an odd count that can never finish are set up from idle in the same way.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
    localparam int          CFG_WRMODE  = 0;
    localparam int          CFG_DMAEN   = 2;
    localparam int          CFG_THR_LO  = 8;
    localparam int          CFG_THR_W   = 7;
    localparam int          CFG_CS_LO   = 24;
    localparam int          CFG_CS_W    = 3;
    localparam logic [31:0] CFG_MASK    = 32'h7F8F_7FBF;
    localparam logic [31:0] CFG_RESET   = 32'h0000_4000;
    localparam int          IRQ_W       = 12;
    localparam logic [11:0] IRQ_EN_MASK = 12'hF03;

    typedef enum logic [2:0] {
        RA_CFG    = 3'd0,
        RA_COUNT  = 3'd1,
        RA_CTRL   = 3'd2,
        RA_STATUS = 3'd3,
        RA_ISTAT  = 3'd4,
        RA_IEN    = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/nfe_fifo_mem.sv
module nfe_fifo_mem #(
    parameter int DEPTH = 64,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we0,
    input  logic [PTR_W-1:0] wa0,
    input  logic [7:0]       wd0,
    input  logic             we1,
    input  logic [PTR_W-1:0] wa1,
    input  logic [7:0]       wd1,
    input  logic [PTR_W-1:0] ra,
    output logic [7:0]       rd
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we0) mem_q[wa0] <= wd0;
        if (we1) mem_q[wa1] <= wd1;
    end

    assign rd = mem_q[ra];
endmodule

// File: rtl/nfe_irq.sv
module nfe_irq
    import nfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_ev,
    input  logic             set_term,
    input  logic             stat_wr,
    input  logic             en_wr,
    input  logic [IRQ_W-1:0] wdata,
    output logic [IRQ_W-1:0] stat,
    output logic [IRQ_W-1:0] en,
    output logic             irq
);
    typedef struct packed {
        logic [IRQ_W-1:0] stat;
        logic [IRQ_W-1:0] en;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_wr) st_d.stat = st_q.stat & ~wdata;
        if (en_wr)   st_d.en   = wdata & IRQ_EN_MASK;
        if (set_ev)   st_d.stat[0] = 1'b1;
        if (set_term) st_d.stat[1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;
    assign en   = st_q.en;
    assign irq  = |(st_q.stat & st_q.en);

    // R7: the interrupt only rises after an enable write or a status source fired
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(en_wr) || $past(set_ev) || $past(set_term)));
endmodule

// File: rtl/nand_fifo_engine.sv
module nand_fifo_engine
    import nfe_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        fifo_rd,
    output logic [7:0]  fifo_rdata,
    input  logic        fifo_wr,
    input  logic [7:0]  fifo_wdata,
    input  logic        dev_wide,
    output logic        nand_req,
    output logic        nand_we,
    output logic [2:0]  nand_cs,
    output logic [15:0] nand_wdata,
    input  logic        nand_ack,
    input  logic [15:0] nand_rdata,
    output logic        irq,
    output logic        dma_req
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int OCC_W = PTR_W + 1;
    localparam int CMP_W = 16;

    typedef struct packed {
        logic [31:0]      cfg;
        logic [CNT_W-1:0] xfer;
        logic             start;
        logic [CNT_W-1:0] remain;
        logic [OCC_W-1:0] occ;
        logic [PTR_W-1:0] rptr;
        logic [PTR_W-1:0] wptr;
        logic [OCC_W-1:0] fill;
        logic             filling;
        logic [7:0]       last;
        logic [7:0]       rdata;
        logic             half;
        logic [7:0]       hold;
        logic             wpend;
        logic [15:0]      wdata;
        logic             dma;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic [CFG_THR_W-1:0] thr;
    logic                 wr_mode, dma_en, ge;
    logic                 mem_we0, mem_we1;
    logic [PTR_W-1:0]     mem_wa0, mem_wa1;
    logic [7:0]           mem_rd;
    logic                 trig, term_set;
    logic [OCC_W-1:0]     space, fill_n;
    logic [IRQ_W-1:0]     istat, ien;

    assign thr     = st_q.cfg[CFG_THR_LO +: CFG_THR_W];
    assign wr_mode = st_q.cfg[CFG_WRMODE];
    assign dma_en  = st_q.cfg[CFG_DMAEN];
    assign ge      = CMP_W'(st_q.occ) >= CMP_W'(thr);

    nfe_fifo_mem #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_mem (
        .clk (clk),
        .we0 (mem_we0), .wa0 (mem_wa0), .wd0 (nand_rdata[7:0]),
        .we1 (mem_we1), .wa1 (mem_wa1), .wd1 (nand_rdata[15:8]),
        .ra  (st_q.rptr), .rd (mem_rd)
    );

    nfe_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (ge),
        .set_term (term_set),
        .stat_wr  (reg_wr && reg_addr == RA_ISTAT),
        .en_wr    (reg_wr && reg_addr == RA_IEN),
        .wdata    (reg_wdata[IRQ_W-1:0]),
        .stat     (istat),
        .en       (ien),
        .irq      (irq)
    );

    always_comb begin
        st_d     = st_q;
        term_set = 1'b0;
        trig     = 1'b0;
        mem_we0  = 1'b0;
        mem_we1  = 1'b0;
        mem_wa0  = st_q.wptr;
        mem_wa1  = st_q.wptr + PTR_W'(1);
        space    = '0;
        fill_n   = '0;

        // a fill burst has delivered its last unit
        if (st_q.filling && st_q.fill == '0) begin
            st_d.filling = 1'b0;
            if (dma_en && st_q.occ != '0) st_d.dma = 1'b1;
            if (st_q.start && st_q.remain == '0) begin
                st_d.start = 1'b0;
                term_set   = 1'b1;
            end
        end

        // NAND read data returned
        if (nand_ack && st_q.fill != '0 && !st_q.wpend) begin
            mem_we0 = 1'b1;
            if (dev_wide) begin
                mem_we1     = 1'b1;
                st_d.wptr   = st_q.wptr + PTR_W'(2);
                st_d.occ    = st_q.occ + OCC_W'(2);
                st_d.fill   = st_q.fill - OCC_W'(2);
                st_d.remain = st_q.remain - CNT_W'(2);
            end else begin
                st_d.wptr   = st_q.wptr + PTR_W'(1);
                st_d.occ    = st_q.occ + OCC_W'(1);
                st_d.fill   = st_q.fill - OCC_W'(1);
                st_d.remain = st_q.remain - CNT_W'(1);
            end
        end
        if (nand_ack && st_q.wpend) st_d.wpend = 1'b0;

        // consumer read
        if (fifo_rd) begin
            if (wr_mode) begin
                st_d.rdata = 8'h00;
            end else if (st_q.occ != '0) begin
                st_d.rdata = mem_rd;
                st_d.last  = mem_rd;
                st_d.rptr  = st_q.rptr + PTR_W'(1);
                st_d.occ   = st_d.occ - OCC_W'(1);
                if (CMP_W'(st_d.occ) == CMP_W'(DEPTH) - CMP_W'(thr)) begin
                    st_d.dma = 1'b0;
                    trig     = 1'b1;
                end
            end else begin
                st_d.rdata = st_q.last;
            end
        end

        // producer write (postwrite)
        if (fifo_wr && wr_mode && st_q.remain != '0 && !st_q.wpend) begin
            if (dev_wide && !st_q.half) begin
                st_d.hold = fifo_wdata;
                st_d.half = 1'b1;
                st_d.occ  = OCC_W'(DEPTH - 1);
            end else begin
                st_d.wpend  = 1'b1;
                st_d.wdata  = dev_wide ? {fifo_wdata, st_q.hold} : {8'h00, fifo_wdata};
                st_d.half   = 1'b0;
                st_d.occ    = OCC_W'(DEPTH);
                st_d.remain = st_q.remain - CNT_W'(1);
                if (st_d.remain == '0) begin
                    st_d.start = 1'b0;
                    term_set   = 1'b1;
                end
            end
        end

        // register writes
        if (reg_wr) begin
            case (reg_addr)
                RA_CFG:   if (!st_q.start) st_d.cfg  = reg_wdata & CFG_MASK;
                RA_COUNT: if (!st_q.start) st_d.xfer = reg_wdata[CNT_W-1:0];
                RA_CTRL: begin
                    if (reg_wdata[0] != st_q.start) begin
                        st_d.start = reg_wdata[0];
                        if (reg_wdata[0]) begin
                            st_d.remain = st_q.xfer;
                            st_d.half   = 1'b0;
                            st_d.rptr   = '0;
                            st_d.wptr   = '0;
                            st_d.dma    = 1'b0;
                            if (wr_mode) begin
                                st_d.occ = OCC_W'(DEPTH);
                            end else begin
                                st_d.occ = '0;
                                trig     = 1'b1;
                            end
                        end else begin
                            st_d.remain = '0;
                            st_d.fill   = '0;
                        end
                    end
                end
                default: ;
            endcase
        end

        // launch a fill burst
        if (trig && st_d.fill == '0) begin
            space = OCC_W'(DEPTH) - st_d.occ;
            if (CMP_W'(st_d.remain) < CMP_W'(space)) fill_n = OCC_W'(st_d.remain);
            else                                      fill_n = space;
            if (dev_wide) fill_n[0] = 1'b0;
            st_d.fill    = fill_n;
            st_d.filling = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cfg <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CFG:    reg_rdata = st_q.cfg;
            RA_COUNT:  reg_rdata[CNT_W-1:0] = st_q.xfer;
            RA_CTRL:   reg_rdata[0] = st_q.start;
            RA_STATUS: begin
                reg_rdata[24 +: OCC_W]  = st_q.occ;
                reg_rdata[16]           = ge;
                reg_rdata[CNT_W-1:0]    = st_q.remain;
            end
            RA_ISTAT:  reg_rdata[IRQ_W-1:0] = istat;
            RA_IEN:    reg_rdata[IRQ_W-1:0] = ien;
            default:   reg_rdata = '0;
        endcase
    end

    assign nand_req   = (st_q.fill != '0) || st_q.wpend;
    assign nand_we    = st_q.wpend;
    assign nand_wdata = st_q.wdata;
    assign nand_cs    = st_q.cfg[CFG_CS_LO +: CFG_CS_W];
    assign fifo_rdata = st_q.rdata;
    assign dma_req    = st_q.dma;

    // R2: configuration cannot move while the engine runs
    p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |=> $stable(st_q.cfg));
    // R4: occupancy never exceeds the FIFO depth
    p_occ_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        CMP_W'(st_q.occ) <= CMP_W'(DEPTH));
    // R5: terminal count always coincides with the engine stopping
    p_term_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(istat[1]) |-> !st_q.start);
    // R8: DMA request only rises with DMA enabled
    p_dma_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(st_q.cfg[CFG_DMAEN]));
    // R9: NAND reads are never issued in write mode
    p_no_read_in_wmode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_req && !nand_we) |-> !wr_mode);
endmodule

// File: tb/nand_fifo_engine_tb_top.sv
module nand_fifo_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        fifo_rd, fifo_wr;
    logic [7:0]  fifo_rdata, fifo_wdata;
    logic        dev_wide;
    logic        nand_req, nand_we, nand_ack;
    logic [2:0]  nand_cs;
    logic [15:0] nand_wdata, nand_rdata;
    logic        irq, dma_req;

    int          n_tests = 0, n_fail = 0;
    int          src_idx = 0;
    logic [15:0] wr_log [$];
    logic [15:0] e_log [$];
    logic        dma_allowed = 1'b1;
    logic        dma_bad = 1'b0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_fifo_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_rd(fifo_rd),
        .fifo_rdata(fifo_rdata), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .dev_wide(dev_wide), .nand_req(nand_req), .nand_we(nand_we),
        .nand_cs(nand_cs), .nand_wdata(nand_wdata), .nand_ack(nand_ack),
        .nand_rdata(nand_rdata), .irq(irq), .dma_req(dma_req)
    );

    function automatic logic [7:0] sbyte(int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    // NAND device model: always acknowledges, serves a fixed byte stream
    assign nand_ack   = 1'b1;
    assign nand_rdata = dev_wide ? {sbyte(src_idx + 1), sbyte(src_idx)} : {8'h00, sbyte(src_idx)};

    always @(posedge clk) begin
        if (nand_req && nand_ack && !nand_we) src_idx <= src_idx + (dev_wide ? 2 : 1);
        if (nand_req && nand_ack && nand_we)  wr_log.push_back(nand_wdata);
        if (rst_n && dma_req && !dma_allowed) dma_bad <= 1'b1;
    end

    // reference model state
    int          m_occ, m_rem, m_thr, m_xfer, m_base, m_cons;
    logic        m_start, m_dmaen, m_wmode, m_wide, m_dma, m_ev, m_term, m_half;
    logic [7:0]  m_last, m_hold;
    logic [31:0] m_cfg;
    logic [11:0] m_en;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic upd_ev();
        if (m_occ >= m_thr) m_ev = 1'b1;
    endtask

    task automatic m_fill();
        int n;
        n = 64 - m_occ;
        if (m_rem < n) n = m_rem;
        if (m_wide) n = n & ~1;
        m_occ += n;
        m_rem -= n;
        if (m_start && m_rem == 0) begin m_term = 1'b1; m_start = 1'b0; end
        if (m_dmaen && m_occ != 0) m_dma = 1'b1;
        upd_ev();
    endtask

    task automatic reg_write(logic [2:0] a, logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic settle();
        int quiet = 0;
        while (quiet < 3) begin
            @(negedge clk);
            if (nand_req) quiet = 0; else quiet++;
        end
    endtask

    task automatic set_cfg(logic [31:0] v);
        reg_write(3'd0, v);
        if (!m_start) begin
            m_cfg   = v & 32'h7F8F7FBF;
            m_thr   = int'(m_cfg[14:8]);
            m_dmaen = m_cfg[2];
            m_wmode = m_cfg[0];
        end
        upd_ev();
        settle();
    endtask

    task automatic set_count(int v);
        reg_write(3'd1, 32'(v));
        if (!m_start) m_xfer = v & 16'h3FFF;
    endtask

    task automatic set_ctrl(logic v);
        int base_now;
        base_now = src_idx;
        reg_write(3'd2, {31'd0, v});
        if (v != m_start) begin
            m_start = v;
            if (v) begin
                m_rem = m_xfer; m_half = 1'b0; m_dma = 1'b0;
                if (m_wmode) m_occ = 64;
                else begin m_occ = 0; m_base = base_now; m_cons = 0; m_fill(); end
            end else begin
                m_rem = 0;
            end
        end
        upd_ev();
        settle();
    endtask

    task automatic istat_clear(logic [11:0] v);
        reg_write(3'd4, {20'd0, v});
        if (v[0]) m_ev = 1'b0;
        if (v[1]) m_term = 1'b0;
        upd_ev();
    endtask

    task automatic compare_all(string req);
        logic [31:0] v, e;
        reg_read(3'd3, v);
        e = (32'(m_occ) << 24) | ((m_occ >= m_thr) ? 32'h10000 : 32'h0) | 32'(m_rem);
        chk({req, " status"}, v, e);
        reg_read(3'd2, v);
        chk({req, " start"}, v, {31'd0, m_start});
        reg_read(3'd4, v);
        chk({req, " istat"}, v, {30'd0, m_term, m_ev});
        chk({req, " irq"}, {31'd0, irq}, {31'd0, ((({m_term, m_ev}) & m_en[1:0]) != 2'b00)});
        chk({req, " dma_req"}, {31'd0, dma_req}, {31'd0, m_dma});
    endtask

    task automatic cpu_read(string req);
        logic [7:0] exp;
        @(negedge clk); fifo_rd = 1'b1;
        @(negedge clk); fifo_rd = 1'b0;
        if (m_wmode) exp = 8'h00;
        else if (m_occ > 0) begin
            exp = sbyte(m_base + m_cons);
            m_cons++; m_occ--; m_last = exp;
            if (m_occ == 64 - m_thr) begin m_dma = 1'b0; m_fill(); end
        end else exp = m_last;
        chk({req, " data"}, {24'd0, fifo_rdata}, {24'd0, exp});
        upd_ev();
        settle();
    endtask

    task automatic cpu_write(logic [7:0] b);
        @(negedge clk); fifo_wr = 1'b1; fifo_wdata = b;
        @(negedge clk); fifo_wr = 1'b0;
        if (m_wmode && m_rem != 0) begin
            if (m_wide && !m_half) begin m_hold = b; m_half = 1'b1; m_occ = 63; end
            else begin
                e_log.push_back(m_wide ? {b, m_hold} : {8'h00, b});
                m_half = 1'b0; m_occ = 64; m_rem--;
                if (m_rem == 0) begin m_term = 1'b1; m_start = 1'b0; end
            end
        end
        upd_ev();
        settle();
    endtask

    task automatic check_log(string req);
        chk({req, " write count"}, 32'(wr_log.size()), 32'(e_log.size()));
        if (wr_log.size() == e_log.size())
            foreach (e_log[i]) chk({req, " write data"}, {16'd0, wr_log[i]}, {16'd0, e_log[i]});
    endtask

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        fifo_rd = 1'b0; fifo_wr = 1'b0; fifo_wdata = '0; dev_wide = 1'b0;
        m_occ = 0; m_rem = 0; m_thr = 64; m_xfer = 0; m_base = 0; m_cons = 0;
        m_start = 0; m_dmaen = 0; m_wmode = 0; m_wide = 0; m_dma = 0;
        m_ev = 0; m_term = 0; m_half = 0; m_last = 0; m_hold = 0;
        m_cfg = 32'h4000; m_en = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values and write mask
        reg_read(3'd0, v); chk("R1 cfg reset", v, 32'h4000);
        compare_all("R1 reset");
        set_cfg(32'hFFFF_FFFF);
        reg_read(3'd0, v); chk("R1 cfg mask", v, 32'h7F8F_7FBF);
        set_cfg(32'h0000_4000);
        // R7 enable mask
        reg_write(3'd5, 32'hFFFF_FFFF); m_en = 12'hF03;
        reg_read(3'd5, v); chk("R7 enable mask", v, 32'h0000_0F03);

        // R3 R4 R5 R8 R9: 8-bit prefetch, threshold 16, DMA on, 100 bytes
        set_cfg(32'h0300_1084);
        set_count(100);
        set_ctrl(1'b1);
        chk("R1 chip select", {29'd0, nand_cs}, 32'd3);
        compare_all("R3 start read");
        for (int i = 0; i < 101; i++) begin
            cpu_read("R4 prefetch");
            compare_all("R8 prefetch");
        end
        compare_all("R5 done");
        cpu_write(8'h5A);
        check_log("R9 write in read mode");
        // R7 write-one-to-clear
        istat_clear(12'h003);
        compare_all("R7 clear");
        // R6 level event re-asserts
        set_cfg(32'h0000_0000);
        istat_clear(12'h001);
        compare_all("R6 level");
        istat_clear(12'h003);

        // R4 R11: 16-bit prefetch of an odd count, then forced stop
        dev_wide = 1'b1; m_wide = 1'b1;
        set_cfg(32'h0000_0400);
        set_count(7);
        set_ctrl(1'b1);
        dma_allowed = 1'b0;
        compare_all("R4 wide fill");
        for (int i = 0; i < 7; i++) cpu_read("R4 wide");
        set_ctrl(1'b0);
        compare_all("R11 wide stop");

        // R2 R11: locked config, forced stop and drain
        dev_wide = 1'b0; m_wide = 1'b0;
        set_cfg(32'h0000_2000);
        set_count(200);
        set_ctrl(1'b1);
        compare_all("R3 second start");
        set_cfg(32'h0000_0000);
        reg_read(3'd0, v); chk("R2 cfg locked", v, 32'h0000_2000);
        set_count(5);
        reg_read(3'd1, v); chk("R2 count locked", v, 32'd200);
        set_ctrl(1'b0);
        compare_all("R11 stop");
        for (int i = 0; i < 64; i++) cpu_read("R11 drain");
        compare_all("R11 drained");

        // R3 R5 R9: 8-bit postwrite of 3 bytes
        set_cfg(32'h0000_0001);
        set_count(3);
        set_ctrl(1'b1);
        compare_all("R3 start write");
        cpu_write(8'hA1); compare_all("R9 write");
        cpu_write(8'hB2); compare_all("R9 write");
        cpu_write(8'hC3); compare_all("R5 write done");
        cpu_write(8'hD4); compare_all("R9 write after end");
        check_log("R9 postwrite");
        cpu_read("R9 read in write mode");

        // R10: 16-bit postwrite pairing
        dev_wide = 1'b1; m_wide = 1'b1;
        set_count(2);
        set_ctrl(1'b1);
        cpu_write(8'h11); compare_all("R10 half held");
        cpu_write(8'h22); compare_all("R10 pair");
        cpu_write(8'h33); compare_all("R10 half held");
        cpu_write(8'h44); compare_all("R10 pair done");
        check_log("R10 halfwords");

        chk("R8 dma disabled", {31'd0, dma_bad}, 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
            $finish;
        end
    end
endmodule